// File: doc/BRIEF.md
# Field-Masked Polled Alarm Comparator

This block decides when a real-time clock's polled alarm fires. It holds seven threshold bytes and a seven-bit enable mask. The thresholds cover seconds, minutes, hours, date of month, month, weekday and year. The block compares the enabled thresholds against the live timekeeping fields once per seconds update. When every enabled field is equal, it raises a sticky alarm flag.

Software polls the flag instead of taking an interrupt. The flag appears as the top bit of the minutes byte whenever that byte is read through the block's read port. Any read or write of the mask or of a threshold byte clears the flag. There is no dedicated clear bit.

Register access is a simple strobed port. Address 0 is the mask. Addresses 1 to 7 are the thresholds, in the field order of the mask bits. Address 8 is the minutes view. Read data is combinational from the read address. The read strobe only marks the access as a read and has no other role.

Top module: `alarm_cmp`

## Requirements
- R1: Mask bit k enables field k, with bit 0 = seconds, bit 1 = minutes, bit 2 = hours, bit 3 = date, bit 4 = month, bit 5 = weekday and bit 6 = year. A field whose bit is 0 takes no part in the match.
- R2: In a cycle with `tick` high, if the mask is nonzero and every enabled threshold equals its live field, the flag reads 1 from the next clock edge on.
- R3: With a mask of 00h the flag never sets, whatever the time fields.
- R4: The hours comparison uses all 8 bits of the hours byte. This includes bit 7 (12/24-hour mode) and bit 5 (PM or 20-hour bit), so a byte that differs only in bit 7 does not match.
- R5: Once set, the flag stays 1 through later ticks whose fields do not match, until a clearing access.
- R6: A cycle with `wr_en` high and `wr_addr` in 0..7, or with `rd_en` high and `rd_addr` in 0..7, clears the flag at the next edge. This clear wins over a set in the same cycle.
- R7: The flag rises only at the edge ending a cycle with `tick` high. Matching fields without a tick, including after a clear, leave it at 0.
- R8: `rd_addr` = 8 returns {flag, live minutes bits 6:0}. An access to address 8 does not clear the flag.
- R9: After reset the mask reads 00h, every threshold reads 00h and the flag is 0.
- R10: Address 0 stores only bits 6:0 of the written byte and reads bit 7 as 0. Addresses 1..7 store and return the full written byte, at address 1+k for field k of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | One-cycle pulse per seconds update, live fields valid in that cycle |
| cur_sec | input | 8 | Live seconds byte |
| cur_min | input | 8 | Live minutes byte |
| cur_hour | input | 8 | Live hours byte (mode and AM/PM bits included) |
| cur_date | input | 8 | Live date-of-month byte |
| cur_month | input | 8 | Live month byte |
| cur_wday | input | 8 | Live weekday byte |
| cur_year | input | 8 | Live year byte |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe (marks the access as a read) |
| rd_addr | input | 4 | Read address |
| rd_data | output | 8 | Combinational read data |

## Verification
The assertions assume that `tick` is a single-cycle pulse. They also assume that the live fields hold steady during a tick cycle, and that register strobes arrive synchronously with the clock. The bench drives every input on the falling edge and raises `tick` for exactly one cycle. It changes the time fields only outside tick cycles. It observes the flag by placing address 8 on the read port with the strobe low, so observation itself never clears the flag.

// File: rtl/alarm_cmp_pkg.sv
package alarm_cmp_pkg;
  localparam int FIELD_W    = 8;
  localparam int NUM_FIELDS = 7;
  localparam int ADDR_W     = 4;

  localparam logic [ADDR_W-1:0] ADDR_CFG      = 4'd0;
  localparam logic [ADDR_W-1:0] ADDR_MIN_VIEW = 4'd8;

  typedef enum int unsigned {
    F_SEC   = 0,
    F_MIN   = 1,
    F_HOUR  = 2,
    F_DATE  = 3,
    F_MONTH = 4,
    F_WDAY  = 5,
    F_YEAR  = 6
  } field_e;
endpackage

// File: rtl/alarm_cmp_rstsync.sv
module alarm_cmp_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_ns = sync_q[STAGES-1];
endmodule

// File: rtl/alarm_cmp_regs.sv
module alarm_cmp_regs #(
  parameter int FW = 8,
  parameter int NF = 7,
  parameter int AW = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_addr,
  input  logic [FW-1:0]          wr_data,
  input  logic                   rd_en,
  input  logic [AW-1:0]          rd_addr,
  output logic [NF-1:0]          mask_o,
  output logic [NF-1:0][FW-1:0]  thr_o,
  output logic                   access_o
);
  localparam logic [AW-1:0] LAST_ADDR = AW'(NF);

  logic              mask_en;
  logic [NF-1:0]     mask_q;
  logic [NF-1:0]     thr_en;

  always_comb begin
    mask_en = wr_en && (wr_addr == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= wr_data[NF-1:0];
  end

  for (genvar i = 0; i < NF; i++) begin : g_thr
    logic [FW-1:0] thr_q;

    always_comb begin
      thr_en[i] = wr_en && (wr_addr == AW'(i + 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         thr_q <= '0;
      else if (thr_en[i]) thr_q <= wr_data;
    end

    assign thr_o[i] = thr_q;
  end

  always_comb begin
    access_o = (wr_en && (wr_addr <= LAST_ADDR)) ||
               (rd_en && (rd_addr <= LAST_ADDR));
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/alarm_cmp_match.sv
module alarm_cmp_match #(
  parameter int FW = 8,
  parameter int NF = 7
) (
  input  logic [NF-1:0]          mask,
  input  logic [NF-1:0][FW-1:0]  thr,
  input  logic [NF-1:0][FW-1:0]  cur,
  output logic                   hit
);
  logic [NF-1:0] field_eq;

  for (genvar i = 0; i < NF; i++) begin : g_cmp
    assign field_eq[i] = (thr[i] == cur[i]);
  end

  always_comb begin
    hit = (|mask) && (&(field_eq | ~mask));
  end
endmodule

// File: rtl/alarm_cmp_flag.sv
module alarm_cmp_flag #(
  parameter int NF = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          hit,
  input  logic          clr,
  input  logic [NF-1:0] mask,
  output logic          flag_o
);
  logic flag_q;
  logic flag_d;
  logic flag_en;

  always_comb begin
    flag_en = clr || (tick && hit);
    flag_d  = clr ? 1'b0 : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  AST_SET_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(tick)); // R7
  AST_NO_SET_EMPTY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> ($past(mask) != '0)); // R3
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !flag_q); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q); // R5
endmodule

// File: rtl/alarm_cmp.sv
module alarm_cmp
  import alarm_cmp_pkg::*;
#(
  parameter int FW = FIELD_W,
  parameter int NF = NUM_FIELDS,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [FW-1:0] cur_sec,
  input  logic [FW-1:0] cur_min,
  input  logic [FW-1:0] cur_hour,
  input  logic [FW-1:0] cur_date,
  input  logic [FW-1:0] cur_month,
  input  logic [FW-1:0] cur_wday,
  input  logic [FW-1:0] cur_year,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [FW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [FW-1:0] rd_data
);
  logic                  rst_ns;
  logic [NF-1:0]         mask;
  logic [NF-1:0][FW-1:0] thr;
  logic [NF-1:0][FW-1:0] cur;
  logic                  access;
  logic                  hit;
  logic                  flag;

  always_comb begin
    cur            = '0;
    cur[F_SEC]     = cur_sec;
    cur[F_MIN]     = cur_min;
    cur[F_HOUR]    = cur_hour;
    cur[F_DATE]    = cur_date;
    cur[F_MONTH]   = cur_month;
    cur[F_WDAY]    = cur_wday;
    cur[F_YEAR]    = cur_year;
  end

  alarm_cmp_rstsync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  alarm_cmp_regs #(.FW(FW), .NF(NF), .AW(AW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_ns),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .mask_o   (mask),
    .thr_o    (thr),
    .access_o (access)
  );

  alarm_cmp_match #(.FW(FW), .NF(NF)) u_match (
    .mask (mask),
    .thr  (thr),
    .cur  (cur),
    .hit  (hit)
  );

  alarm_cmp_flag #(.NF(NF)) u_flag (
    .clk    (clk),
    .rst_n  (rst_ns),
    .tick   (tick),
    .hit    (hit),
    .clr    (access),
    .mask   (mask),
    .flag_o (flag)
  );

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_CFG) begin
      rd_data = FW'(mask);
    end else if (rd_addr == ADDR_MIN_VIEW) begin
      rd_data = {flag, cur_min[FW-2:0]};
    end else begin
      for (int i = 0; i < NF; i++) begin
        if (rd_addr == AW'(i + 1)) rd_data = thr[i];
      end
    end
  end
endmodule

// File: tb/alarm_cmp_tb.sv
module alarm_cmp_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick;
  logic [7:0] cur_sec, cur_min, cur_hour, cur_date, cur_month, cur_wday, cur_year;
  logic       wr_en;
  logic [3:0] wr_addr;
  logic [7:0] wr_data;
  logic       rd_en;
  logic [3:0] rd_addr;
  logic [7:0] rd_data;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  alarm_cmp u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
    .cur_date(cur_date), .cur_month(cur_month), .cur_wday(cur_wday),
    .cur_year(cur_year),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // {expected flag, mask, year,wday,month,date,hour,min,sec}
  localparam logic [63:0] VEC [10] = '{
    {1'b1, 7'h03, 56'h24050704A21530},  // R1 R2 min+sec match
    {1'b0, 7'h03, 56'h24050704A21531},  // R2 seconds differ
    {1'b1, 7'h03, 56'h24050704221530},  // R1 hour ignored
    {1'b0, 7'h04, 56'h24050704221530},  // R4 mode bit differs
    {1'b1, 7'h7F, 56'h24050704A21530},  // R2 all fields
    {1'b0, 7'h7F, 56'h25050704A21530},  // R2 year differs
    {1'b1, 7'h40, 56'h24000000000000},  // R1 year only
    {1'b0, 7'h00, 56'h24050704A21530},  // R3 empty mask
    {1'b1, 7'h20, 56'h00050000000000},  // R1 weekday only
    {1'b0, 7'h08, 56'h24050705A21530}   // R1 date differs
  };

  localparam logic [55:0] MATCH_ALL = 56'h24050704A21530;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_time(input logic [55:0] t);
    @(negedge clk);
    {cur_year, cur_wday, cur_month, cur_date, cur_hour, cur_min, cur_sec} = t;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic peek(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    rst_n = 1'b0; tick = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    wr_addr = '0; wr_data = '0; rd_addr = '0;
    {cur_year, cur_wday, cur_month, cur_date, cur_hour, cur_min, cur_sec} = MATCH_ALL;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9 reset state
    peek(4'd0, d); chk("R9 mask reset", d, 8'h00);
    peek(4'd4, d); chk("R9 threshold reset", d, 8'h00);
    peek(4'd8, d); chk("R9 flag reset", {7'b0, d[7]}, 8'h00);

    // thresholds: sec 30 min 15 hour A2 date 04 month 07 wday 05 year 24
    wr(4'd1, 8'h30); wr(4'd2, 8'h15); wr(4'd3, 8'hA2); wr(4'd4, 8'h04);
    wr(4'd5, 8'h07); wr(4'd6, 8'h05); wr(4'd7, 8'h24);

    for (int i = 0; i < 10; i++) begin
      set_time(VEC[i][55:0]);
      wr(4'd0, {1'b0, VEC[i][62:56]});
      pulse_tick();
      peek(4'd8, d);
      chk($sformatf("R2 vector %0d flag", i), {7'b0, d[7]}, {7'b0, VEC[i][63]});
    end

    // R5 sticky across non-matching tick
    set_time(MATCH_ALL);
    wr(4'd0, 8'h03);
    pulse_tick();
    set_time(56'h24050704A21531);
    pulse_tick();
    peek(4'd8, d); chk("R5 flag sticky", {7'b0, d[7]}, 8'h01);

    // R8 strobed minutes view returns flag + minutes, no clear
    rd(4'd8, d); chk("R8 minutes view", d, 8'h95);
    peek(4'd8, d); chk("R8 view does not clear", {7'b0, d[7]}, 8'h01);

    // R6 read of threshold clears; R7 no tick no set
    rd(4'd3, d); chk("R10 hour threshold readback", d, 8'hA2);
    set_time(MATCH_ALL);
    repeat (3) @(negedge clk);
    peek(4'd8, d); chk("R6 R7 cleared by read, no re-set without tick", {7'b0, d[7]}, 8'h00);

    // R6 write of threshold clears
    pulse_tick();
    peek(4'd8, d); chk("R7 set on tick", {7'b0, d[7]}, 8'h01);
    wr(4'd5, 8'h07);
    peek(4'd8, d); chk("R6 cleared by threshold write", {7'b0, d[7]}, 8'h00);

    // R6 clear wins over simultaneous set
    @(negedge clk);
    tick = 1'b1; rd_en = 1'b1; rd_addr = 4'd1;
    @(negedge clk);
    tick = 1'b0; rd_en = 1'b0;
    peek(4'd8, d); chk("R6 clear beats set", {7'b0, d[7]}, 8'h00);

    // R10 mask bit 7 dropped
    wr(4'd0, 8'hFF);
    peek(4'd0, d); chk("R10 mask top bit", d, 8'h7F);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule